// File: doc/BRIEF.md
# Limit Counter-Timer Bank with Switchable User Mode

This block is a bank of counters reached over a simple word-addressed register bus. It holds one system counter and `NUM_CPU` processor counters, and each counter has its own interrupt line. All counters advance together on a shared prescaled tick-enable input. Each tick adds one step of 512 sub-units to the count, so the low 9 bits of any count or limit value always read as zero.

A counter in limit mode counts up to a programmable limit. When it reaches the limit it wraps to zero, sets a reached flag and raises its interrupt. Software clears the flag and the interrupt by reading back the limit. A bitmask register in the system counter can switch any processor counter into user mode. In user mode the counter is a free-running 63-bit counter that never interrupts, can be started and stopped, and shows its count as a high word and a low word. Only counters whose mode bit actually changes are disturbed by a write to that mask.

The bus unit number selects a counter: unit 0 is the system counter and unit i+1 is processor counter i. The word number selects a register inside that counter.

Top module: `ct_bank`

## Requirements
- R1: After reset every counter is in limit mode with a count of zero, word 0 reads 0x7FFFFE00, the reached flag is clear, word 3 of a processor counter reads 1 (running), word 4 of unit 0 reads 0, and every interrupt is low.
- R2: A write to word 0 or word 2 in limit mode keeps only bits 30:9 of the data as the limit. If those bits are all zero, the limit becomes 0x7FFFFE00.
- R3: In limit mode each tick-enable cycle adds 0x200 to the count. Word 1 reads the count in bits 30:9, with the reached flag in bit 31.
- R4: In limit mode, a tick that brings the count to or past the limit wraps the count to zero, sets the reached flag (bit 31 of word 1) and raises the counter's interrupt. The interrupt is visible after that clock edge.
- R5: A read of word 0 in limit mode returns the limit in bits 30:9 and clears both the reached flag and the interrupt.
- R6: A write to word 0 in limit mode loads the limit, clears the count and lowers the interrupt. A write to word 2 in limit mode loads the limit and leaves the count unchanged.
- R7: Word 4 of unit 0 holds a mask in which bit i selects user mode (1) or limit mode (0) for unit i+1, and it reads back. On a write to it, each counter whose bit changes restarts: the count is cleared, the counter is running, the reached flag and interrupt are cleared, and the limit becomes 0x7FFFFE00. Counters whose bit is unchanged keep their state.
- R8: In user mode the counter never sets its reached flag or raises its interrupt. Word 0 reads count bits 62:32 and word 1 reads count bits 31:0, with bits 8:0 zero.
- R9: In user mode a write to word 0 or word 1 clears the count and lowers the interrupt.
- R10: In user mode, bit 0 of a word 3 write starts (1) or stops (0) the counter, and a stopped counter holds its count through ticks. Word 3 reads the running status in bit 0. In limit mode, writes to word 3 are ignored.
- R11: Reads of undefined words return zero and writes to them are ignored. Unit 0 decodes words 0, 1, 2 and 4. Processor units decode words 0 to 3. Units above `NUM_CPU` decode nothing. A write to word 1 in limit mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled tick; advances running counters by one step |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_unit | input | UNIT_W | Counter select: 0 system, i+1 processor i |
| bus_word | input | 3 | Register word within the counter |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| irq_sys | output | 1 | System counter interrupt |
| irq_cpu | output | NUM_CPU | Processor counter interrupts |

## Verification
Counting is tried with tiny limits that wrap after a few ticks, with the limit lowered below the current count, and with zero or low-bits-only limit writes. These patterns separate the reach-or-pass comparison from an exact-equality one and confirm the masking of the limit field. Mode changes are tried with one bit flipped while a neighbour's bit stays the same, and with a counter entering user mode while its interrupt is pending. Together these show that only changed counters restart and that a pending interrupt is dropped. A seeded random mix of ticks, reads and writes over all units and words, including undefined ones, is compared against a bench model that tracks the read side effects.

// File: rtl/ct_pkg.sv
// Package: shared widths and register word codes for the counter-timer bank.
// Assumes a 32-bit data bus and a fixed 9-bit step granularity.
package ct_pkg;
    localparam int DATA_W     = 32;
    localparam int STEP_SHIFT = 9;                       // one step = 512 sub-units
    localparam int LIM_W      = 31 - STEP_SHIFT;         // limit field bits 30:9
    localparam int CNT_W      = 63 - STEP_SHIFT;         // user count bits 62:9
    localparam int WORD_W     = 3;

    typedef enum logic [WORD_W-1:0] {
        WD_LIMIT   = 3'd0,   // limit / user high word
        WD_COUNT   = 3'd1,   // count+flag / user low word
        WD_LIM_NR  = 3'd2,   // limit without count reset
        WD_RUN     = 3'd3,   // user start/stop
        WD_MODE    = 3'd4    // user-mode mask (system only)
    } word_e;
endpackage

// File: rtl/ct_counter.sv
// Module: one counter of the bank. Runs in limit mode, or in user mode when
// HAS_USER is set and user_mode is high. Assumes the bus access signals are
// already qualified for this unit and that mode_chg pulses for one cycle on
// the edge where the mode mask updates.
module ct_counter
    import ct_pkg::*;
#(
    parameter bit HAS_USER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              user_mode,
    input  logic              mode_chg,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [WORD_W-1:0] acc_word,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [CNT_W-1:0] cnt_q;
    logic [LIM_W-1:0] lim_q;
    logic             reached_q;
    logic             irq_q;
    logic             run_q;

    logic             is_user;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit;
    logic [LIM_W-1:0] lim_field;
    logic [LIM_W-1:0] lim_new;
    logic             clr_rd;

    // Purpose: derive mode, next count, limit match and the new limit value.
    always_comb begin
        is_user   = HAS_USER && user_mode;
        cnt_inc   = cnt_q + 1'b1;
        hit       = tick_en && run_q && !is_user &&
                    (cnt_inc >= CNT_W'(lim_q));
        lim_field = acc_wdata[STEP_SHIFT +: LIM_W];
        lim_new   = (lim_field == '0) ? '1 : lim_field;
        clr_rd    = acc_rd && (acc_word == WD_LIMIT) && !is_user;
    end

    // Purpose: counter state; later statements take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '1;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            run_q     <= 1'b1;
        end else begin
            if (tick_en && run_q) begin
                cnt_q <= hit ? '0 : cnt_inc;
            end
            if (clr_rd) begin
                reached_q <= 1'b0;
                irq_q     <= 1'b0;
            end
            if (acc_wr) begin
                case (acc_word)
                    WD_LIMIT: begin
                        cnt_q <= '0;
                        irq_q <= 1'b0;
                        if (!is_user) lim_q <= lim_new;
                    end
                    WD_COUNT: begin
                        if (is_user) begin
                            cnt_q <= '0;
                            irq_q <= 1'b0;
                        end
                    end
                    WD_LIM_NR: begin
                        if (!is_user) lim_q <= lim_new;
                    end
                    WD_RUN: begin
                        if (is_user) run_q <= acc_wdata[0];
                    end
                    default: ;
                endcase
            end
            if (hit) begin
                reached_q <= 1'b1;
                irq_q     <= 1'b1;
            end
            if (mode_chg) begin
                cnt_q     <= '0;
                lim_q     <= '1;
                run_q     <= 1'b1;
                reached_q <= 1'b0;
                irq_q     <= 1'b0;
            end
        end
    end

    // Purpose: register read view, which depends on the mode.
    always_comb begin
        case (acc_word)
            WD_LIMIT: rdata = is_user ? {1'b0, cnt_q[CNT_W-1:DATA_W-STEP_SHIFT]}
                                      : {1'b0, lim_q, {STEP_SHIFT{1'b0}}};
            WD_COUNT: rdata = is_user ? {cnt_q[DATA_W-STEP_SHIFT-1:0], {STEP_SHIFT{1'b0}}}
                                      : {reached_q, cnt_q[LIM_W-1:0], {STEP_SHIFT{1'b0}}};
            WD_RUN:   rdata = HAS_USER ? DATA_W'(run_q) : '0;
            default:  rdata = '0;
        endcase
    end

    assign irq = irq_q;
endmodule

// File: rtl/ct_mode_reg.sv
// Module: the user-mode mask held by the system counter. Produces a one-cycle
// change vector on the write edge. Assumes NUM_CPU <= 32.
module ct_mode_reg #(
    parameter int NUM_CPU = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_CPU-1:0] wdata,
    output logic [NUM_CPU-1:0] mode,
    output logic [NUM_CPU-1:0] chg
);
    logic [NUM_CPU-1:0] mode_q;

    // Purpose: hold the mask; all counters start in limit mode.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= '0;
        else if (wr_en) mode_q <= wdata;
    end

    // Purpose: flag the counters whose bit flips on this write.
    always_comb chg = wr_en ? (wdata ^ mode_q) : '0;

    assign mode = mode_q;
endmodule

// File: rtl/ct_rd_mux.sv
// Module: selects one unit's read data. Returns zero when there is no read or
// when the unit number is outside the bank.
module ct_rd_mux #(
    parameter int N_UNITS = 3,
    parameter int UNIT_W  = 2
) (
    input  logic [N_UNITS-1:0][31:0] unit_rdata,
    input  logic [UNIT_W-1:0]        unit_sel,
    input  logic                     rd,
    output logic [31:0]              rdata
);
    // Purpose: index the selected unit and gate the result with the read strobe.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < N_UNITS; k++) begin
            if (rd && (int'(unit_sel) == k)) rdata = unit_rdata[k];
        end
    end
endmodule

// File: rtl/ct_bank.sv
// Module: the top of the counter-timer bank. It has one limit-only system counter
// (unit 0) that also holds the user-mode mask, and NUM_CPU switchable processor
// counters (units 1..NUM_CPU). Assumes one bus access per cycle.
module ct_bank
    import ct_pkg::*;
#(
    parameter  int NUM_CPU = 2,
    localparam int UNIT_W  = $clog2(NUM_CPU + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [UNIT_W-1:0]  bus_unit,
    input  logic [2:0]         bus_word,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_sys,
    output logic [NUM_CPU-1:0] irq_cpu
);
    localparam int N_UNITS = NUM_CPU + 1;

    logic [N_UNITS-1:0]        sel;
    logic [N_UNITS-1:0][31:0]  unit_rdata;
    logic [31:0]               sys_cnt_rdata;
    logic [NUM_CPU-1:0]        mode_q;
    logic [NUM_CPU-1:0]        mode_chg;
    logic                      mode_wr;
    logic                      bus_rd;

    // Purpose: decode the unit select and the mask write.
    always_comb begin
        for (int k = 0; k < N_UNITS; k++) sel[k] = bus_en && (int'(bus_unit) == k);
        bus_rd  = bus_en && !bus_we;
        mode_wr = sel[0] && bus_we && (bus_word == WD_MODE);
    end

    ct_mode_reg #(.NUM_CPU(NUM_CPU)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mode_wr),
        .wdata (bus_wdata[NUM_CPU-1:0]),
        .mode  (mode_q),
        .chg   (mode_chg)
    );

    ct_counter #(.HAS_USER(1'b0)) u_sys (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .user_mode (1'b0),
        .mode_chg  (1'b0),
        .acc_wr    (sel[0] && bus_we),
        .acc_rd    (sel[0] && !bus_we),
        .acc_word  (bus_word),
        .acc_wdata (bus_wdata),
        .rdata     (sys_cnt_rdata),
        .irq       (irq_sys)
    );

    // Purpose: merge the mask read into the system unit's read view.
    always_comb begin
        unit_rdata[0] = sys_cnt_rdata;
        if (bus_word == WD_MODE) unit_rdata[0] = 32'(mode_q);
    end

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        ct_counter #(.HAS_USER(1'b1)) u_cpu (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_en   (tick_en),
            .user_mode (mode_q[g]),
            .mode_chg  (mode_chg[g]),
            .acc_wr    (sel[g+1] && bus_we),
            .acc_rd    (sel[g+1] && !bus_we),
            .acc_word  (bus_word),
            .acc_wdata (bus_wdata),
            .rdata     (unit_rdata[g+1]),
            .irq       (irq_cpu[g])
        );
    end

    ct_rd_mux #(.N_UNITS(N_UNITS), .UNIT_W(UNIT_W)) u_rmux (
        .unit_rdata (unit_rdata),
        .unit_sel   (bus_unit),
        .rd         (bus_rd),
        .rdata      (bus_rdata)
    );
endmodule

// File: rtl/ct_bank_chk.sv
// Module: protocol checker for ct_bank, bound to every instance of it.
module ct_bank_chk #(
    parameter int NUM_CPU = 2,
    parameter int UNIT_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic               bus_en,
    input logic               bus_we,
    input logic [UNIT_W-1:0]  bus_unit,
    input logic [2:0]         bus_word,
    input logic [31:0]        bus_rdata,
    input logic               irq_sys,
    input logic [NUM_CPU-1:0] irq_cpu,
    input logic [NUM_CPU-1:0] mode_q
);
    // R8: a counter in user mode never has its interrupt high
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_usr
        assert_user_irq_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            mode_q[g] |-> !irq_cpu[g]);
    end

    // R4: the system interrupt only rises on a tick
    assert_irq_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_sys) |-> $past(tick_en));

    // R5: reading the limit without a tick leaves the interrupt low
    assert_limit_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_unit == '0 && bus_word == 3'd0 && !tick_en) |=> !irq_sys);

    // R7: the mode mask changes only after a write to unit 0, word 4
    assert_mode_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(bus_en && bus_we && bus_unit == '0 && bus_word == 3'd4));

    // R11: undefined words read as zero
    assert_undef_word_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_word > 3'd4) |-> bus_rdata == 32'd0);
endmodule

bind ct_bank ct_bank_chk #(.NUM_CPU(NUM_CPU), .UNIT_W(UNIT_W)) u_ct_bank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_unit  (bus_unit),
    .bus_word  (bus_word),
    .bus_rdata (bus_rdata),
    .irq_sys   (irq_sys),
    .irq_cpu   (irq_cpu),
    .mode_q    (mode_q)
);

// File: tb/ct_bank_bench.sv
// Bench: directed corner cases followed by seeded random traffic, all compared
// against a model of the requirements kept in bench functions.
module ct_bank_bench;
    localparam int NCPU = 2;
    localparam int NU   = NCPU + 1;
    localparam longint unsigned STEP_MASK = (64'd1 << 54) - 1;
    localparam int unsigned LIM_MAX = 32'h3F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_unit = '0;
    logic [2:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_sys;
    logic [NCPU-1:0] irq_cpu;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    longint unsigned m_cnt[NU];
    int unsigned     m_lim[NU];
    bit              m_rch[NU];
    bit              m_irq[NU];
    bit              m_run[NU];
    bit [NCPU-1:0]   m_mode;

    always #4 clk = ~clk;

    ct_bank #(.NUM_CPU(NCPU)) u_ct_bank (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en),
        .bus_we(bus_we), .bus_unit(bus_unit), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_sys(irq_sys),
        .irq_cpu(irq_cpu)
    );

    function automatic bit is_usr(int u);
        return (u > 0) && (u < NU) && m_mode[u-1];
    endfunction

    function automatic int unsigned lim_of(logic [31:0] d);
        int unsigned v = (d >> 9) & LIM_MAX;
        return (v == 0) ? LIM_MAX : v;
    endfunction

    function automatic logic [31:0] exp_rd(int u, int w);
        if (u >= NU) return 32'd0;
        case (w)
            0: return is_usr(u) ? 32'(m_cnt[u] >> 23) : 32'(m_lim[u] << 9);
            1: return is_usr(u) ? 32'((m_cnt[u] & 64'h7F_FFFF) << 9)
                                : ((m_rch[u] ? 32'h8000_0000 : 32'd0) |
                                   32'((m_cnt[u] & 64'h3F_FFFF) << 9));
            3: return (u > 0) ? 32'(m_run[u]) : 32'd0;
            4: return (u == 0) ? 32'(m_mode) : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic void restart(int u);
        m_cnt[u] = 0; m_lim[u] = LIM_MAX; m_rch[u] = 0; m_irq[u] = 0; m_run[u] = 1;
    endfunction

    function automatic void m_tick();
        for (int u = 0; u < NU; u++) begin
            if (m_run[u]) begin
                if (!is_usr(u)) begin
                    if (m_cnt[u] + 1 >= m_lim[u]) begin
                        m_cnt[u] = 0; m_rch[u] = 1; m_irq[u] = 1;
                    end else m_cnt[u] = m_cnt[u] + 1;
                end else m_cnt[u] = (m_cnt[u] + 1) & STEP_MASK;
            end
        end
    endfunction

    function automatic void m_write(int u, int w, logic [31:0] d);
        bit usr = is_usr(u);
        if (u >= NU) return;
        case (w)
            0: begin m_cnt[u] = 0; m_irq[u] = 0; if (!usr) m_lim[u] = lim_of(d); end
            1: if (usr) begin m_cnt[u] = 0; m_irq[u] = 0; end
            2: if (!usr) m_lim[u] = lim_of(d);
            3: if (usr) m_run[u] = d[0];
            4: if (u == 0) begin
                for (int i = 0; i < NCPU; i++) if (d[i] != m_mode[i]) restart(i + 1);
                m_mode = d[NCPU-1:0];
            end
            default: ;
        endcase
    endfunction

    function automatic void m_read(int u, int w);
        if (u < NU && w == 0 && !is_usr(u)) begin m_rch[u] = 0; m_irq[u] = 0; end
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_irq();
        logic [31:0] e = '0;
        e[0] = m_irq[0];
        for (int i = 0; i < NCPU; i++) e[i+1] = m_irq[i+1];
        check("R4/R5/R8 irq lines", 32'({irq_cpu, irq_sys}), e);
    endtask

    task automatic idle_after_edge();
        @(posedge clk); #1;
        tick_en = 0; bus_en = 0; bus_we = 0;
    endtask

    task automatic op_tick();
        @(negedge clk); check_irq();
        tick_en = 1;
        idle_after_edge();
        m_tick();
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) op_tick();
    endtask

    task automatic op_wr(int u, int w, logic [31:0] d);
        @(negedge clk); check_irq();
        bus_en = 1; bus_we = 1; bus_unit = 2'(u); bus_word = 3'(w); bus_wdata = d;
        idle_after_edge();
        m_write(u, w, d);
    endtask

    task automatic op_rd(int u, int w, string req);
        logic [31:0] got;
        @(negedge clk); check_irq();
        bus_en = 1; bus_we = 0; bus_unit = 2'(u); bus_word = 3'(w);
        #2 got = bus_rdata;
        check(req, got, exp_rd(u, w));
        idle_after_edge();
        m_read(u, w);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int u = 0; u < NU; u++) restart(u);
        m_mode = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state
        for (int u = 0; u < NU; u++) begin
            op_rd(u, 0, "R1 limit after reset");
            op_rd(u, 1, "R1 count after reset");
        end
        op_rd(1, 3, "R1 running after reset");
        op_rd(0, 4, "R1 mask after reset");

        // R2: masking and zero limit
        op_wr(0, 0, 32'h0000_0A37); op_rd(0, 0, "R2 masked limit");
        op_wr(1, 0, 32'h0000_01FF); op_rd(1, 0, "R2 zero limit is max");
        op_wr(2, 2, 32'hFFFF_FFFF); op_rd(2, 0, "R2 bit 31 dropped");

        // R3, R4: count and wrap on system unit (limit 5 steps)
        ticks(3); op_rd(0, 1, "R3 count after three ticks");
        ticks(2); op_rd(0, 1, "R4 wrap sets reached");
        // R5: limit read clears flag and irq
        op_rd(0, 0, "R5 limit read");
        op_rd(0, 1, "R5 reached cleared");

        // R6: word 2 keeps count, word 0 resets it; lower below count
        ticks(3);
        op_wr(0, 2, 32'h0000_1000); op_rd(0, 1, "R6 count kept on word 2");
        op_wr(0, 2, 32'h0000_0400); ticks(1); op_rd(0, 1, "R4 limit passed wraps");
        ticks(1); op_wr(0, 0, 32'h0000_0800); op_rd(0, 1, "R6 count reset on word 0");

        // R7: switch unit 1 to user, unit 2 must keep its state
        op_wr(2, 0, 32'h0000_0E00); ticks(2);
        op_wr(0, 4, 32'h1);
        op_rd(0, 4, "R7 mask readback");
        op_rd(2, 1, "R7 unchanged unit keeps count");
        op_rd(1, 1, "R7 changed unit restarted");

        // R8: user mode counting, no irq
        ticks(9);
        op_rd(1, 0, "R8 user high word");
        op_rd(1, 1, "R8 user low word");
        // R9: user reset via word 1
        op_wr(1, 1, 32'h1234_5678); op_rd(1, 1, "R9 user count cleared");

        // R10: stop, hold, restart; word 3 ignored in limit mode
        ticks(2); op_wr(1, 3, 32'h0);
        op_rd(1, 3, "R10 stopped status");
        ticks(4); op_rd(1, 1, "R10 stopped count holds");
        op_wr(1, 3, 32'h1); ticks(2); op_rd(1, 1, "R10 restarted count");
        op_wr(2, 3, 32'h0); op_rd(2, 3, "R10 limit-mode word 3 ignored");

        // R7: entering user mode drops a pending interrupt
        op_wr(2, 0, 32'h0000_0400); ticks(2);
        op_wr(0, 4, 32'h3); op_rd(2, 1, "R7 entered user cleared");
        op_wr(0, 4, 32'h0); op_rd(1, 0, "R7 back to limit max");

        // R11: undefined words and units
        op_rd(0, 3, "R11 system word 3");
        op_rd(1, 4, "R11 cpu word 4");
        for (int w = 5; w < 8; w++) op_rd(0, w, "R11 undefined word");
        op_rd(3, 0, "R11 undefined unit");
        op_wr(3, 4, 32'h3); op_rd(0, 4, "R11 undefined unit write ignored");
        ticks(2); op_wr(2, 1, 32'h0); op_rd(2, 1, "R11 word 1 write ignored in limit mode");
        op_wr(1, 6, 32'hFFFF_FFFF); op_rd(1, 0, "R11 undefined word write ignored");

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int r = $urandom % 10;
            int u = $urandom % 4;
            int w = ($urandom % 4 == 0) ? $urandom % 8 : $urandom % 5;
            logic [31:0] d = (($urandom % 7) << 9) | ($urandom & 32'h1FF);
            if (w == 3 || w == 4) d = $urandom % 4;
            if (r < 5) op_tick();
            else if (r < 7) op_wr(u, w, d);
            else op_rd(u, w, "R3/R8/R11 random read");
        end
        @(negedge clk); check_irq();

        done = 1;
        summary();
        $finish;
    end
endmodule